// File: doc/BRIEF.md
# Time-Triggered Bus Cycle Scheduler

This block produces the communication timing of one node on a time-triggered automotive bus. A microtick enable from the node's local oscillator is divided into macroticks. The macroticks step a repeating communication cycle through four segments in a fixed order: the fixed-schedule segment, the flexible segment, the symbol window and the network idle time. The block reports the current segment, the running slot number, a 6-bit cycle number, a transmit-enable window and a one-clock action-point strobe at every slot or minislot boundary.

In the fixed-schedule segment every slot has the same length, and the node owns the slot whose number equals its frame ID. In the flexible segment time is cut into minislots. A slot whose number equals the node's frame ID can open a transmission only on a minislot boundary. The transmission then holds the slot counter still while it occupies several minislots. Empty flexible slots cost one minislot each, so access is ordered by slot number and no two nodes contend.

Every configuration value is at least 1. Clock synchronisation, frame coding and the physical layer are handled elsewhere.

Top module: `ttbus_cycle_sched`

## Requirements
- R1: `seg_o` visits the segments in the order fixed-schedule (0), flexible (1), symbol window (2), network idle (3), then returns to 0, every cycle.
- R2: One macrotick is `cfg_ut_per_mt` clocks with `ut_en` high. Clocks with `ut_en` low change no output, and `ap_o` is low on them.
- R3: The segments last `cfg_n_static*cfg_mt_per_slot`, `cfg_n_mslot*cfg_mt_per_mslot`, `cfg_sym_mt` and `cfg_idle_mt` macroticks respectively.
- R4: `slot_o` is 1 at cycle start and rises by one per fixed slot. It continues without restarting into the flexible segment, rising by one after each empty minislot and after each transmission. It is 0 in the symbol window and in the idle time.
- R5: In the fixed-schedule segment, `tx_en_o` is high for the whole slot whose number equals `node_id`, whatever `tx_req` is.
- R6: A flexible slot whose number equals `node_id` is granted when it opens if `tx_req` is high and `tx_len` is at least 1. It then lasts `tx_len+1` minislots, `tx_en_o` is high for exactly that span, and `slot_o` stays frozen throughout.
- R7: A grant is refused when `tx_len+1` exceeds the minislots left in the flexible segment. That slot then lasts one minislot with `tx_en_o` low, and no transmission happens for the rest of the cycle. An exact fit is granted.
- R8: A flexible slot with `tx_req` low or `tx_len` equal to 0, or whose number differs from `node_id`, lasts one minislot with `tx_en_o` low.
- R9: `ap_o` pulses for one clock at the start of every fixed slot and every minislot, including the minislot boundaries inside a transmission and the start of each cycle. The first slot after reset gets no pulse.
- R10: `cycle_o` increments when the idle time ends and wraps from 63 to 0.
- R11: The configuration inputs are captured during reset and when each cycle starts. Changes made in the middle of a cycle take effect only from the next cycle.
- R12: During reset the outputs are: segment 0, slot 1, cycle 0, `ap_o` low, and `tx_en_o` equal to (`node_id`==1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ut_en | input | 1 | Microtick enable |
| cfg_ut_per_mt | input | 8 | Microticks per macrotick |
| cfg_mt_per_slot | input | 8 | Macroticks per fixed slot |
| cfg_n_static | input | 8 | Number of fixed slots |
| cfg_mt_per_mslot | input | 8 | Macroticks per minislot |
| cfg_n_mslot | input | 8 | Number of minislots |
| cfg_sym_mt | input | 8 | Symbol window length in macroticks |
| cfg_idle_mt | input | 8 | Network idle length in macroticks |
| node_id | input | 10 | Frame ID owned by this node |
| tx_req | input | 1 | Flexible-segment transmit request |
| tx_len | input | 8 | Frame length in minislots |
| seg_o | output | 2 | Current segment |
| slot_o | output | 10 | Slot counter |
| cycle_o | output | 6 | Cycle counter |
| tx_en_o | output | 1 | Transmit-enable window |
| ap_o | output | 1 | Action-point strobe |

## Verification
The bench sweeps every macrotick of several small cycles and goes after these corner cases:
- Frames that fit the remaining minislots exactly, and frames that miss by one. A design with an off-by-one in the fit test either sends past the segment end or drops a legal frame.
- A zero length or an absent request. A design that ignored either would stretch an empty slot.
- Minislot boundaries inside a frame. A design that froze the strobe along with the slot counter would miss these action points.
- A configuration change in the middle of a cycle. A design that did not hold its configuration would bend the current cycle.
- The stall clocks of a gapped microtick enable, and the counter wrap after 64 cycles, which would show a wrong modulus.

// File: rtl/ttsched_pkg.sv
package ttsched_pkg;

    localparam int CW = 8;
    localparam int SW = CW + 2;

    typedef enum logic [1:0] {
        SEG_STATIC = 2'd0,
        SEG_DYN    = 2'd1,
        SEG_SYM    = 2'd2,
        SEG_IDLE   = 2'd3
    } seg_e;

    typedef struct packed {
        logic [CW-1:0] ut_per_mt;
        logic [CW-1:0] mt_per_slot;
        logic [CW-1:0] n_static;
        logic [CW-1:0] mt_per_mslot;
        logic [CW-1:0] n_mslot;
        logic [CW-1:0] sym_mt;
        logic [CW-1:0] idle_mt;
    } cfg_t;

    typedef struct packed {
        logic          grant;
        logic [CW:0]   len_ms;
    } slot_open_t;

    typedef struct packed {
        seg_e          seg;
        logic [CW-1:0] mtc;
        logic [SW-1:0] slot;
        logic [CW-1:0] msc;
        logic [CW:0]   sub;
        logic [CW:0]   len;
        logic          tx;
        logic          ap;
    } tstate_t;

    function automatic seg_e seg_after(seg_e s);
        case (s)
            SEG_STATIC: return SEG_DYN;
            SEG_DYN:    return SEG_SYM;
            SEG_SYM:    return SEG_IDLE;
            default:    return SEG_STATIC;
        endcase
    endfunction

endpackage

// File: rtl/tts_cfg_latch.sv
module tts_cfg_latch
    import ttsched_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  cfg_t cfg_in,
    output cfg_t cfg_q
);
    always_ff @(posedge clk) begin
        if (rst || load) begin
            cfg_q <= cfg_in;
        end
    end
endmodule

// File: rtl/tts_mtgen.sv
module tts_mtgen
    import ttsched_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          ut_en,
    input  logic [CW-1:0] ut_per_mt,
    output logic          mt_tick
);
    logic [CW-1:0] utc_q;

    assign mt_tick = ut_en && (utc_q == ut_per_mt - CW'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            utc_q <= '0;
        end else if (ut_en) begin
            utc_q <= mt_tick ? '0 : utc_q + CW'(1);
        end
    end

    // R2
    utc_range_chk: assert property (@(posedge clk) disable iff (rst)
        utc_q < ut_per_mt);

    // R2
    utc_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(ut_en) && !$past(rst)) |-> $stable(utc_q));
endmodule

// File: rtl/tts_dyn_grant.sv
module tts_dyn_grant
    import ttsched_pkg::*;
(
    input  logic [SW-1:0] slot_i,
    input  logic [CW-1:0] ms_done_i,
    input  logic [CW-1:0] n_mslot_i,
    input  logic [SW-1:0] node_id_i,
    input  logic          tx_req_i,
    input  logic [CW-1:0] tx_len_i,
    output slot_open_t    open_o
);
    logic [CW-1:0] left_ms;
    logic [CW:0]   need_ms;
    logic          fits;

    always_comb begin
        left_ms      = n_mslot_i - ms_done_i;
        need_ms      = {1'b0, tx_len_i} + (CW+1)'(1);
        fits         = need_ms <= {1'b0, left_ms};
        open_o.grant = tx_req_i && (tx_len_i != '0) && (slot_i == node_id_i) && fits;
        open_o.len_ms = open_o.grant ? need_ms : (CW+1)'(1);
    end

    // R6
    always_comb begin
        if (open_o.grant) begin
            len_min_chk: assert (open_o.len_ms >= (CW+1)'(2));
        end
    end
endmodule

// File: rtl/tts_seq.sv
module tts_seq
    import ttsched_pkg::*;
#(
    parameter int CYC_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             mt_tick,
    input  logic [CW-1:0]    mt_per_slot,
    input  logic [CW-1:0]    n_static,
    input  logic [CW-1:0]    mt_per_mslot,
    input  logic [CW-1:0]    n_mslot,
    input  logic [CW-1:0]    sym_mt,
    input  logic [CW-1:0]    idle_mt,
    input  logic [SW-1:0]    node_id,
    input  logic             tx_req,
    input  logic [CW-1:0]    tx_len,
    output tstate_t          st_o,
    output logic [CYC_W-1:0] cyc_o,
    output logic             cyc_start
);
    tstate_t          st_q, st_d;
    logic [CYC_W-1:0] cyc_q, cyc_d;
    logic [CW-1:0]    unit_mt;
    logic             last_mt;
    logic             last_sub;
    logic [CW:0]      ms_new;
    logic [CW-1:0]    ms_in;
    logic [SW-1:0]    slot_inc;
    slot_open_t       gnt;

    always_comb begin
        unique case (st_q.seg)
            SEG_STATIC: unit_mt = mt_per_slot;
            SEG_DYN:    unit_mt = mt_per_mslot;
            SEG_SYM:    unit_mt = sym_mt;
            default:    unit_mt = idle_mt;
        endcase
        last_mt  = st_q.mtc == unit_mt - CW'(1);
        last_sub = st_q.sub == st_q.len - (CW+1)'(1);
        ms_new   = {1'b0, st_q.msc} + st_q.len;
        ms_in    = (st_q.seg == SEG_STATIC) ? '0 : ms_new[CW-1:0];
        slot_inc = st_q.slot + SW'(1);
    end

    tts_dyn_grant u_grant (
        .slot_i    (slot_inc),
        .ms_done_i (ms_in),
        .n_mslot_i (n_mslot),
        .node_id_i (node_id),
        .tx_req_i  (tx_req),
        .tx_len_i  (tx_len),
        .open_o    (gnt)
    );

    assign cyc_start = mt_tick && last_mt && (st_q.seg == SEG_IDLE);

    always_comb begin
        st_d    = st_q;
        st_d.ap = 1'b0;
        cyc_d   = cyc_q;
        if (mt_tick) begin
            if (!last_mt) begin
                st_d.mtc = st_q.mtc + CW'(1);
            end else begin
                st_d.mtc = '0;
                unique case (st_q.seg)
                    SEG_STATIC: begin
                        st_d.slot = slot_inc;
                        st_d.ap   = 1'b1;
                        if (st_q.slot == {{(SW-CW){1'b0}}, n_static}) begin
                            st_d.seg = SEG_DYN;
                            st_d.msc = '0;
                            st_d.sub = '0;
                            st_d.len = gnt.len_ms;
                            st_d.tx  = gnt.grant;
                        end else begin
                            st_d.tx  = slot_inc == node_id;
                        end
                    end
                    SEG_DYN: begin
                        if (!last_sub) begin
                            st_d.sub = st_q.sub + (CW+1)'(1);
                            st_d.ap  = 1'b1;
                        end else if (ms_new == {1'b0, n_mslot}) begin
                            st_d.seg  = SEG_SYM;
                            st_d.slot = '0;
                            st_d.msc  = '0;
                            st_d.sub  = '0;
                            st_d.len  = (CW+1)'(1);
                            st_d.tx   = 1'b0;
                        end else begin
                            st_d.slot = slot_inc;
                            st_d.msc  = ms_new[CW-1:0];
                            st_d.sub  = '0;
                            st_d.len  = gnt.len_ms;
                            st_d.tx   = gnt.grant;
                            st_d.ap   = 1'b1;
                        end
                    end
                    SEG_SYM: begin
                        st_d.seg = SEG_IDLE;
                    end
                    default: begin
                        st_d.seg  = SEG_STATIC;
                        st_d.slot = SW'(1);
                        st_d.tx   = node_id == SW'(1);
                        st_d.ap   = 1'b1;
                        cyc_d     = cyc_q + CYC_W'(1);
                    end
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.seg  <= SEG_STATIC;
            st_q.mtc  <= '0;
            st_q.slot <= SW'(1);
            st_q.msc  <= '0;
            st_q.sub  <= '0;
            st_q.len  <= (CW+1)'(1);
            st_q.tx   <= node_id == SW'(1);
            st_q.ap   <= 1'b0;
            cyc_q     <= '0;
        end else begin
            st_q  <= st_d;
            cyc_q <= cyc_d;
        end
    end

    assign st_o  = st_q;
    assign cyc_o = cyc_q;

    // R1
    seg_order_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q.seg != $past(st_q.seg)) |-> (st_q.seg == seg_after($past(st_q.seg))));

    // R5
    tx_seg_chk: assert property (@(posedge clk) disable iff (rst)
        st_q.tx |-> (st_q.seg == SEG_STATIC || st_q.seg == SEG_DYN));

    // R4
    slot_step_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q.slot != $past(st_q.slot) && st_q.slot > SW'(1))
            |-> (st_q.slot == $past(st_q.slot) + SW'(1)));

    // R6
    slot_freeze_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q.seg == SEG_DYN && st_q.sub != '0) |-> $stable(st_q.slot));

    // R7
    frame_fit_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q.seg == SEG_DYN && st_q.tx)
            |-> (({1'b0, st_q.msc} + st_q.len) <= {1'b0, n_mslot}));

    // R9
    ap_tick_chk: assert property (@(posedge clk) disable iff (rst)
        st_q.ap |-> $past(mt_tick));

    // R10
    cyc_step_chk: assert property (@(posedge clk) disable iff (rst)
        (cyc_q != $past(cyc_q)) |-> ($past(st_q.seg) == SEG_IDLE
            && st_q.seg == SEG_STATIC && cyc_q == $past(cyc_q) + CYC_W'(1)));
endmodule

// File: rtl/ttbus_cycle_sched.sv
module ttbus_cycle_sched
    import ttsched_pkg::*;
#(
    parameter int CYC_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ut_en,
    input  logic [CW-1:0]    cfg_ut_per_mt,
    input  logic [CW-1:0]    cfg_mt_per_slot,
    input  logic [CW-1:0]    cfg_n_static,
    input  logic [CW-1:0]    cfg_mt_per_mslot,
    input  logic [CW-1:0]    cfg_n_mslot,
    input  logic [CW-1:0]    cfg_sym_mt,
    input  logic [CW-1:0]    cfg_idle_mt,
    input  logic [SW-1:0]    node_id,
    input  logic             tx_req,
    input  logic [CW-1:0]    tx_len,
    output logic [1:0]       seg_o,
    output logic [SW-1:0]    slot_o,
    output logic [CYC_W-1:0] cycle_o,
    output logic             tx_en_o,
    output logic             ap_o
);
    cfg_t    cfg_in, cfg_q;
    logic    mt_tick;
    logic    cyc_start;
    tstate_t st;

    always_comb begin
        cfg_in.ut_per_mt    = cfg_ut_per_mt;
        cfg_in.mt_per_slot  = cfg_mt_per_slot;
        cfg_in.n_static     = cfg_n_static;
        cfg_in.mt_per_mslot = cfg_mt_per_mslot;
        cfg_in.n_mslot      = cfg_n_mslot;
        cfg_in.sym_mt       = cfg_sym_mt;
        cfg_in.idle_mt      = cfg_idle_mt;
    end

    tts_cfg_latch u_cfg (
        .clk    (clk),
        .rst    (rst),
        .load   (cyc_start),
        .cfg_in (cfg_in),
        .cfg_q  (cfg_q)
    );

    tts_mtgen u_mt (
        .clk       (clk),
        .rst       (rst),
        .ut_en     (ut_en),
        .ut_per_mt (cfg_q.ut_per_mt),
        .mt_tick   (mt_tick)
    );

    tts_seq #(.CYC_W(CYC_W)) u_seq (
        .clk          (clk),
        .rst          (rst),
        .mt_tick      (mt_tick),
        .mt_per_slot  (cfg_q.mt_per_slot),
        .n_static     (cfg_q.n_static),
        .mt_per_mslot (cfg_q.mt_per_mslot),
        .n_mslot      (cfg_q.n_mslot),
        .sym_mt       (cfg_q.sym_mt),
        .idle_mt      (cfg_q.idle_mt),
        .node_id      (node_id),
        .tx_req       (tx_req),
        .tx_len       (tx_len),
        .st_o         (st),
        .cyc_o        (cycle_o),
        .cyc_start    (cyc_start)
    );

    assign seg_o   = st.seg;
    assign slot_o  = st.slot;
    assign tx_en_o = st.tx;
    assign ap_o    = st.ap;

    // R11
    cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(cyc_start) |-> $stable(cfg_q));
endmodule

// File: tb/tb_ttbus_cycle_sched.sv
module tb_ttbus_cycle_sched;
    localparam int TCLK = 10;

    typedef struct {
        int u; int mps; int ns; int mpm; int nm; int sym; int idle;
    } bcfg_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ut_en = 1'b0;
    logic [7:0] c_u, c_mps, c_ns, c_mpm, c_nm, c_sym, c_idle;
    logic [9:0] node_id;
    logic       tx_req;
    logic [7:0] tx_len;
    logic [1:0] seg;
    logic [9:0] slot;
    logic [5:0] cyc;
    logic       tx_en;
    logic       ap;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done  = 1'b0;

    always #(TCLK/2) clk = ~clk;

    ttbus_cycle_sched dut (
        .clk(clk), .rst(rst), .ut_en(ut_en),
        .cfg_ut_per_mt(c_u), .cfg_mt_per_slot(c_mps), .cfg_n_static(c_ns),
        .cfg_mt_per_mslot(c_mpm), .cfg_n_mslot(c_nm), .cfg_sym_mt(c_sym),
        .cfg_idle_mt(c_idle), .node_id(node_id), .tx_req(tx_req), .tx_len(tx_len),
        .seg_o(seg), .slot_o(slot), .cycle_o(cyc), .tx_en_o(tx_en), .ap_o(ap)
    );

    task automatic chk_eq(input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    task automatic drive_cfg(input bcfg_t c);
        c_u = 8'(c.u); c_mps = 8'(c.mps); c_ns = 8'(c.ns); c_mpm = 8'(c.mpm);
        c_nm = 8'(c.nm); c_sym = 8'(c.sym); c_idle = 8'(c.idle);
    endtask

    function automatic int cyc_len(input bcfg_t c);
        return c.ns*c.mps + c.nm*c.mpm + c.sym + c.idle;
    endfunction

    task automatic expect_at(input bcfg_t c, input int node, input bit req,
                             input int len, input int m, output int e_seg,
                             output int e_slot, output int e_tx, output int e_ap);
        int s_len;
        int d_len;
        s_len = c.ns*c.mps;
        d_len = c.nm*c.mpm;
        e_ap = 0; e_tx = 0; e_slot = 0;
        if (m < s_len) begin
            e_seg  = 0;
            e_slot = m/c.mps + 1;
            e_tx   = int'(e_slot == node);
            e_ap   = int'(m % c.mps == 0);
        end else if (m < s_len + d_len) begin
            int k;
            int ms;
            int sl;
            k = (m - s_len)/c.mpm;
            ms = 0;
            sl = c.ns + 1;
            e_seg = 1;
            e_ap  = int'((m - s_len) % c.mpm == 0);
            for (int g = 0; g < 1000; g++) begin
                bit ok;
                int l;
                ok = req && len >= 1 && sl == node && (len + 1 <= c.nm - ms);
                l  = ok ? len + 1 : 1;
                if (k < ms + l) begin
                    e_slot = sl;
                    e_tx   = int'(ok);
                    break;
                end
                ms += l;
                sl++;
            end
        end else if (m < s_len + d_len + c.sym) begin
            e_seg = 2;
        end else begin
            e_seg = 3;
        end
    endtask

    task automatic mt_step(input string name, input int u, input bit gap,
                           input int slot_b, input int seg_b);
        for (int i = 0; i < u; i++) begin
            if (gap) begin
                ut_en = 1'b0;
                @(negedge clk);
                chk_eq({name, " R2 slot held on stall"}, int'(slot), slot_b);
                chk_eq({name, " R2 ap low on stall"}, int'(ap), 0);
            end
            ut_en = 1'b1;
            @(negedge clk);
            if (i < u - 1) begin
                chk_eq({name, " R9 ap low mid-macrotick"}, int'(ap), 0);
                chk_eq({name, " R2 seg held mid-macrotick"}, int'(seg), seg_b);
            end
        end
    endtask

    task automatic run_scn(input string name, input bcfg_t a, input bcfg_t b,
                           input int sw_m, input int node, input bit req,
                           input int len, input bit gap, input int ncyc,
                           input string dyn_tag);
        bcfg_t act;
        bcfg_t pend;
        drive_cfg(a);
        node_id = 10'(node); tx_req = req; tx_len = 8'(len);
        ut_en = 1'b0; rst = 1'b1;
        @(negedge clk); @(negedge clk);
        chk_eq({name, " R12 reset seg"}, int'(seg), 0);
        chk_eq({name, " R12 reset slot"}, int'(slot), 1);
        chk_eq({name, " R12 reset cycle"}, int'(cyc), 0);
        chk_eq({name, " R12 reset ap"}, int'(ap), 0);
        chk_eq({name, " R12 reset tx"}, int'(tx_en), int'(node == 1));
        rst = 1'b0;
        act = a; pend = a;
        for (int c = 0; c < ncyc; c++) begin
            if (c > 0) act = pend;
            for (int m = 0; m < cyc_len(act); m++) begin
                int es, esl, etx, eap;
                expect_at(act, node, req, len, m, es, esl, etx, eap);
                if (c == 0 && m == 0) eap = 0;
                chk_eq({name, " R1 R3 segment"}, int'(seg), es);
                chk_eq({name, " R4 slot"}, int'(slot), esl);
                chk_eq({name, es == 0 ? " R5 static tx" : {" ", dyn_tag, " tx"}},
                       int'(tx_en), etx);
                chk_eq({name, " R9 action point"}, int'(ap), eap);
                chk_eq({name, " R10 cycle"}, int'(cyc), c % 64);
                if (c == 0 && m == sw_m) begin
                    drive_cfg(b);
                    pend = b;
                end
                mt_step(name, act.u, gap, int'(slot), int'(seg));
            end
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    endtask

    initial begin
        bcfg_t ca, cb, ct;
        ca = '{u:2, mps:3, ns:4, mpm:2, nm:8, sym:2, idle:3};
        cb = '{u:1, mps:2, ns:2, mpm:1, nm:5, sym:1, idle:1};
        ct = '{u:1, mps:1, ns:1, mpm:1, nm:1, sym:1, idle:1};
        run_scn("static-no-req", ca, ca, -1, 2, 1'b0, 3, 1'b0, 2, "R8");
        run_scn("dyn-grant", ca, ca, -1, 6, 1'b1, 3, 1'b1, 2, "R6");
        run_scn("dyn-no-req", ca, ca, -1, 6, 1'b0, 3, 1'b0, 2, "R8");
        run_scn("dyn-len0", ca, ca, -1, 6, 1'b1, 0, 1'b0, 2, "R8");
        run_scn("dyn-miss-by-one", ca, ca, -1, 10, 1'b1, 3, 1'b0, 2, "R7");
        run_scn("dyn-exact-fit", ca, ca, -1, 9, 1'b1, 3, 1'b0, 2, "R7");
        run_scn("dyn-whole-seg", ca, ca, -1, 5, 1'b1, 7, 1'b1, 2, "R6");
        run_scn("R11-cfg-switch", ca, cb, 2, 3, 1'b1, 2, 1'b0, 3, "R6");
        run_scn("wrap", ct, ct, -1, 1, 1'b0, 1, 1'b0, 66, "R8");
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired actual=0 expected=1");
            summary();
            $finish;
        end
    end
endmodule